// File: doc/BRIEF.md
# Per-Lane Pending Request Counter

This block keeps score of the memory requests still outstanding for each lane of one vector memory instruction in flight. Every lane owns a two-bit count that can only hold 0, 1 or 2. A lane whose access fits inside one cache line waits for one response. A lane whose access crosses a line boundary waits for two. An idle lane waits for none.

At the start of an instruction the issue logic clears all lanes and loads each lane's request count in the same cycle. Each returning response names its lane, and that lane's count drops by one. A memory-sync response wipes every lane at once. A fence is tracked by clearing all lanes and loading lane 0 with one. The block raises a one-cycle completion pulse when the counts move from some nonzero state to all zero. Illegal commands are flagged on an error output: a load value above two, or a decrement of a lane that is already empty. In that cycle the stored counts do not move.

Top module: `lane_pend_tracker`

## Requirements
- R1: After reset every lane count is 0 and both `done_o` and `err_o` are low.
- R2: A lane selected in `set_mask_i` with a value of 0, 1 or 2 in its field `set_val_i[2i+1:2i]` shows that value on `cnt_o[2i+1:2i]` in the following cycle. Unselected lanes keep their counts.
- R3: `clr_all_i` zeroes every lane in the following cycle. Loads presented in the same cycle are applied after the clear. Clear plus a load of 1 into lane 0 therefore leaves only lane 0 at 1.
- R4: `dec_vld_i` with lane index `dec_lane_i` lowers that lane's count by one in the following cycle and leaves every other lane unchanged.
- R5: When a load and a decrement target the same lane in one cycle, the loaded value wins, the decrement is dropped and no error is raised.
- R6: A load value of 3 on any selected lane raises `err_o` for one cycle in the following cycle. No lane changes in that cycle, including lanes loaded or decremented legally alongside it.
- R7: A decrement of a lane whose count is 0, with no load, clear or sync on it, raises `err_o` in the following cycle. No lane changes in that cycle.
- R8: `sync_i` zeroes every lane in the following cycle. It overrides loads and decrements in the same cycle and never raises `err_o`.
- R9: `done_o` is high for exactly one cycle, the first cycle in which all counts are zero after a cycle in which some count was nonzero. It stays low while the counts simply remain zero.
- R10: No lane count ever exceeds 2, and `done_o` and `err_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| clr_all_i | input | 1 | Clear all lanes; loads in the same cycle apply afterwards |
| set_mask_i | input | NUM_LANES | Lanes to load this cycle |
| set_val_i | input | 2*NUM_LANES | Load value per lane, lane i in bits [2i+1:2i] |
| dec_vld_i | input | 1 | One response arrived this cycle |
| dec_lane_i | input | $clog2(NUM_LANES) | Lane the response belongs to |
| sync_i | input | 1 | Memory-sync response: clear every lane |
| cnt_o | output | 2*NUM_LANES | Registered per-lane counts, lane i in bits [2i+1:2i] |
| done_o | output | 1 | One-cycle pulse on the move to all-zero |
| err_o | output | 1 | One-cycle flag for an illegal load or an underflow |

## Verification
Several commands can reach one lane in the same cycle, and they must resolve by priority. A load and a response decrement can target one lane together, and a sync can arrive together with both. The bench drives these combinations in a single cycle. It checks that the loaded value survives with no error flagged, and that a sync leaves every lane at zero whatever else was asserted. It also pairs an illegal load with legal loads and a decrement in one cycle, and it judges the result by confirming that every lane's count is unchanged in the next cycle.

// File: rtl/lpt_pkg.sv
package lpt_pkg;
    localparam int CNT_W = 2;
    typedef logic [CNT_W-1:0] cnt_t;
    localparam cnt_t CNT_MAX = cnt_t'(2);
endpackage

// File: rtl/lpt_lane_next.sv
module lpt_lane_next
    import lpt_pkg::*;
(
    input  cnt_t cnt_q,
    input  logic clr_i,
    input  logic sync_i,
    input  logic set_en_i,
    input  cnt_t set_val_i,
    input  logic dec_i,
    output cnt_t cnt_nxt_o,
    output logic bad_set_o,
    output logic underflow_o
);
    // priority: sync > load > clear > decrement
    always_comb begin
        bad_set_o   = set_en_i && !sync_i && (set_val_i > CNT_MAX);
        underflow_o = dec_i && !set_en_i && !clr_i && !sync_i && (cnt_q == '0);
        if (sync_i)        cnt_nxt_o = '0;
        else if (set_en_i) cnt_nxt_o = set_val_i;
        else if (clr_i)    cnt_nxt_o = '0;
        else if (dec_i && cnt_q != '0) cnt_nxt_o = cnt_q - cnt_t'(1);
        else               cnt_nxt_o = cnt_q;
    end
endmodule

// File: rtl/lpt_all_zero.sv
module lpt_all_zero #(
    parameter int W = 128
) (
    input  logic [W-1:0] vec_i,
    output logic         zero_o
);
    assign zero_o = ~|vec_i;
endmodule

// File: rtl/lane_pend_tracker.sv
module lane_pend_tracker
    import lpt_pkg::*;
#(
    parameter int NUM_LANES = 64,
    localparam int IDX_W = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1,
    localparam int VEC_W = NUM_LANES * CNT_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr_all_i,
    input  logic [NUM_LANES-1:0] set_mask_i,
    input  logic [VEC_W-1:0]     set_val_i,
    input  logic                 dec_vld_i,
    input  logic [IDX_W-1:0]     dec_lane_i,
    input  logic                 sync_i,
    output logic [VEC_W-1:0]     cnt_o,
    output logic                 done_o,
    output logic                 err_o
);
    typedef struct packed {
        logic [VEC_W-1:0] cnt;
        logic             done;
        logic             err;
    } state_t;

    state_t st_d, st_q;

    logic [VEC_W-1:0]     cnt_nxt;
    logic [NUM_LANES-1:0] bad_set;
    logic [NUM_LANES-1:0] underflow;
    logic                 cur_zero;
    logic                 nxt_zero;

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        logic dec_hit;
        assign dec_hit = dec_vld_i && (dec_lane_i == IDX_W'(g));
        lpt_lane_next u_lane (
            .cnt_q      (st_q.cnt[g*CNT_W +: CNT_W]),
            .clr_i      (clr_all_i),
            .sync_i     (sync_i),
            .set_en_i   (set_mask_i[g]),
            .set_val_i  (set_val_i[g*CNT_W +: CNT_W]),
            .dec_i      (dec_hit),
            .cnt_nxt_o  (cnt_nxt[g*CNT_W +: CNT_W]),
            .bad_set_o  (bad_set[g]),
            .underflow_o(underflow[g])
        );
    end

    lpt_all_zero #(.W(VEC_W)) u_zero_cur (.vec_i(st_q.cnt), .zero_o(cur_zero));
    lpt_all_zero #(.W(VEC_W)) u_zero_nxt (.vec_i(cnt_nxt),  .zero_o(nxt_zero));

    always_comb begin
        st_d = st_q;
        if ((|bad_set) || (|underflow)) begin
            st_d.err  = 1'b1;
            st_d.done = 1'b0;
        end else begin
            st_d.cnt  = cnt_nxt;
            st_d.err  = 1'b0;
            st_d.done = !cur_zero && nxt_zero;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o  = st_q.cnt;
    assign done_o = st_q.done;
    assign err_o  = st_q.err;
endmodule

// File: rtl/lpt_checker.sv
module lpt_checker #(
    parameter int NUM_LANES = 64,
    localparam int VEC_W = NUM_LANES * 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sync_i,
    input logic [VEC_W-1:0] cnt_o,
    input logic             done_o,
    input logic             err_o
);
    logic over_max;
    always_comb begin
        over_max = 1'b0;
        for (int i = 0; i < NUM_LANES; i++)
            if (cnt_o[i*2 +: 2] == 2'd3) over_max = 1'b1;
    end

    assert_lane_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !over_max);
    assert_done_err_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && err_o));
    assert_done_all_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (cnt_o == '0));
    assert_done_after_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($past(cnt_o) != '0));
    assert_err_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> $stable(cnt_o));
    assert_sync_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sync_i |=> ((cnt_o == '0) && !err_o));
endmodule

bind lane_pend_tracker lpt_checker #(.NUM_LANES(NUM_LANES)) u_lpt_checker (
    .clk   (clk),
    .rst_n (rst_n),
    .sync_i(sync_i),
    .cnt_o (cnt_o),
    .done_o(done_o),
    .err_o (err_o)
);

// File: tb/lane_pend_tracker_bench.sv
module lane_pend_tracker_bench;
    localparam int N     = 64;
    localparam int IDX_W = $clog2(N);

    logic             clk = 1'b0;
    logic             rst_n;
    logic             clr_all_i;
    logic [N-1:0]     set_mask_i;
    logic [2*N-1:0]   set_val_i;
    logic             dec_vld_i;
    logic [IDX_W-1:0] dec_lane_i;
    logic             sync_i;
    logic [2*N-1:0]   cnt_o;
    logic             done_o;
    logic             err_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;
    int exp_cnt [N];

    always #5 clk = ~clk;

    lane_pend_tracker u_lane_pend_tracker (
        .clk(clk), .rst_n(rst_n), .clr_all_i(clr_all_i), .set_mask_i(set_mask_i),
        .set_val_i(set_val_i), .dec_vld_i(dec_vld_i), .dec_lane_i(dec_lane_i),
        .sync_i(sync_i), .cnt_o(cnt_o), .done_o(done_o), .err_o(err_o)
    );

    task automatic idle_inputs();
        clr_all_i = 0; set_mask_i = '0; set_val_i = '0;
        dec_vld_i = 0; dec_lane_i = '0; sync_i = 0;
    endtask

    task automatic load(int lane, int val);
        set_mask_i[lane] = 1'b1;
        set_val_i[2*lane +: 2] = 2'(val);
    endtask

    task automatic dec(int lane);
        dec_vld_i = 1'b1;
        dec_lane_i = IDX_W'(lane);
    endtask

    // apply inputs for one edge, then sample 1 ns after it
    task automatic step();
        @(posedge clk);
        #1;
        idle_inputs();
    endtask

    task automatic check_val(string req, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic check_lanes(string req);
        int bad_lane = -1;
        n_checks++;
        for (int i = 0; i < N; i++)
            if (bad_lane < 0 && int'(cnt_o[2*i +: 2]) != exp_cnt[i]) bad_lane = i;
        if (bad_lane >= 0) begin
            n_fails++;
            $display("FAIL %s lane %0d: actual %0d expected %0d", req, bad_lane,
                     int'(cnt_o[2*bad_lane +: 2]), exp_cnt[bad_lane]);
        end
    endtask

    task automatic zero_exp();
        for (int i = 0; i < N; i++) exp_cnt[i] = 0;
    endtask

    task automatic t_reset();
        zero_exp();
        check_lanes("R1");
        check_val("R1", "done_o", int'(done_o), 0);
        check_val("R1", "err_o", int'(err_o), 0);
    endtask

    task automatic t_start_and_drain();
        clr_all_i = 1; load(3, 2); load(10, 1); load(63, 2);
        step();
        exp_cnt[3] = 2; exp_cnt[10] = 1; exp_cnt[63] = 2;
        check_lanes("R2");
        check_val("R9", "done_o on load", int'(done_o), 0);
        dec(3); step(); exp_cnt[3] = 1;
        check_lanes("R4");
        dec(10); step(); exp_cnt[10] = 0;
        check_lanes("R4");
        dec(3); step(); exp_cnt[3] = 0;
        dec(63); step(); exp_cnt[63] = 1;
        check_lanes("R4");
        check_val("R9", "done_o early", int'(done_o), 0);
        dec(63); step(); exp_cnt[63] = 0;
        check_lanes("R4");
        check_val("R9", "done_o pulse", int'(done_o), 1);
        step();
        check_val("R9", "done_o after pulse", int'(done_o), 0);
        step();
        check_val("R9", "done_o while idle", int'(done_o), 0);
    endtask

    task automatic t_fence();
        load(40, 2); step(); exp_cnt[40] = 2;
        clr_all_i = 1; load(0, 1); step();
        zero_exp(); exp_cnt[0] = 1;
        check_lanes("R3");
        check_val("R3", "done_o on fence", int'(done_o), 0);
        dec(0); step(); exp_cnt[0] = 0;
        check_val("R3", "done_o fence drain", int'(done_o), 1);
        load(1, 1); step(); exp_cnt[1] = 1;
        clr_all_i = 1; step(); exp_cnt[1] = 0;
        check_lanes("R3");
        check_val("R9", "done_o on clear", int'(done_o), 1);
    endtask

    task automatic t_priority();
        load(5, 2); step(); exp_cnt[5] = 2;
        load(5, 1); dec(5); step(); exp_cnt[5] = 1;
        check_lanes("R5");
        check_val("R5", "err_o", int'(err_o), 0);
    endtask

    task automatic t_bad_load();
        load(7, 3); load(8, 1); dec(5); step();
        check_lanes("R6");
        check_val("R6", "err_o", int'(err_o), 1);
        check_val("R6", "done_o", int'(done_o), 0);
        step();
        check_val("R6", "err_o clears", int'(err_o), 0);
    endtask

    task automatic t_underflow();
        dec(9); step();
        check_lanes("R7");
        check_val("R7", "err_o", int'(err_o), 1);
        dec(5); step(); exp_cnt[5] = 0;
        check_val("R7", "legal dec no err", int'(err_o), 0);
        check_lanes("R7");
    endtask

    task automatic t_sync();
        load(5, 1); load(20, 2); step(); exp_cnt[5] = 1; exp_cnt[20] = 2;
        sync_i = 1; load(30, 2); load(31, 3); dec(5); step();
        zero_exp();
        check_lanes("R8");
        check_val("R8", "err_o", int'(err_o), 0);
        check_val("R9", "done_o on sync", int'(done_o), 1);
    endtask

    initial begin
        rst_n = 0;
        idle_inputs();
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1;
        t_reset();
        t_start_and_drain();
        t_fence();
        t_priority();
        t_bad_load();
        t_underflow();
        t_sync();
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end
endmodule